// File: doc/BRIEF.md
# Sticky Event Status and Dual Interrupt Controller

This block is the status and interrupt hub of a memory-card host controller. The command engine and the data engine report events through one-cycle set pulses, and the block keeps those event flags sticky until software clears them. Level flags for the active state and the FIFO level come in as a vector and are copied into the upper part of the same status word. Two interrupt lines each combine the status word with their own 32-bit enable mask.

The block also answers host reads of a FIFO word count, which is derived from the data engine's remaining byte count. It also paces card-to-FIFO refills: a host read of a FIFO data word stops further refills until software polls either the status word or the FIFO count. The data path is outside this block. It sees only the `refillOk` permit.

Register selects on `regSel`: 0 status, 1 clear, 2 interrupt mask for line 0, 3 interrupt mask for line 1, 4 FIFO word count, 5 FIFO data. Codes 6 and 7 are unused.

Top module: `mmc_status_irq`

## Requirements
- R1: While `rstN` is low and right after it rises, the status word, both masks, `irq0` and `irq1` are 0 and `refillOk` is 1.
- R2: Event bits 0 to 8 and 10 are sticky. A 1 on the matching `evtSet` bit sets the status bit at the next clock edge, and the bit stays set until a clear write removes it.
- R3: Status bit 9 is reserved. It always reads 0, whatever `evtSet[9]` is.
- R4: Status bits 11 to 21 take the value of `evtSet[21:11]` at each clock edge. A clear write has no effect on them.
- R5: A write to select 1 clears each status bit whose position is set in `regWdata[10:0]`. Bits 31 to 11 of the written value are ignored.
- R6: If a clear write and an event set hit the same bit in one cycle, the bit ends up set.
- R7: `irq0` (or `irq1`) is a register. One cycle after any status or mask change, it is 1 exactly when the status word AND mask 0 (or mask 1) is nonzero.
- R8: Writes to select 2 and 3 store all 32 bits, and reads return them unchanged. Writes to selects 0, 4, 5, 6 and 7 change no readable state.
- R9: A read at select 4 returns (`byteRemain` + 3) >> 2, computed without overflow, including for `byteRemain` = 65535.
- R10: A read at select 5 drops `refillOk` to 0 from the next cycle onward. It stays 0 until a read at select 0 or 4.
- R11: A read at select 0 or 4 returns the value as it stands before the release, and `refillOk` returns to 1 in the next cycle.
- R12: Reads at selects 1, 5, 6 and 7 return 0. A status read returns bits 31 to 22 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtSet | input | 22 | Bits 10:0 are event set pulses; bits 21:11 are level flags |
| byteRemain | input | 16 | Remaining byte count of the data engine |
| regSel | input | 3 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational for the current select |
| refillOk | output | 1 | Permit for card-to-FIFO refill |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
An event set and a software clear can land on the same status bit in the same cycle, and the set must win. The bench provokes this in two ways. It writes clear words with all low bits set while `evtSet` pulses chosen bits, and it also lets random traffic overlap clears and pulses freely. Each result is judged against a bench model of the status word on a later status read and on the registered interrupt lines one cycle later. Mask writes that land together with status changes are judged the same way.

// File: rtl/mmcst_pkg.sv
package mmcst_pkg;
  localparam int STAT_W   = 22;
  localparam int CLR_W    = 11;
  localparam int RSVD_BIT = 9;
  localparam int REG_W    = 32;
  localparam int NUM_IRQ  = 2;
  localparam int SEL_W    = 3;

  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CLEAR  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MASK0  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MASK1  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_COUNT  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_FIFO   = 3'd5;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_MASK0, RD_MASK1, RD_COUNT
  } rdSrc_e;

  typedef struct packed {
    logic               clrWr;
    logic [NUM_IRQ-1:0] maskWr;
    rdSrc_e             rdSrc;
  } strobes_t;
endpackage

// File: rtl/mmcst_ctrl.sv
module mmcst_ctrl
  import mmcst_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] regSel,
  input  logic             regWr,
  input  logic             regRd,
  output strobes_t         strobes,
  output logic             refillOk
);
  logic holdQ;
  logic fifoRead;
  logic pollRead;

  assign fifoRead = regRd && (regSel == SEL_FIFO);
  assign pollRead = regRd && ((regSel == SEL_STATUS) || (regSel == SEL_COUNT));

  always_comb begin
    strobes.clrWr     = regWr && (regSel == SEL_CLEAR);
    strobes.maskWr[0] = regWr && (regSel == SEL_MASK0);
    strobes.maskWr[1] = regWr && (regSel == SEL_MASK1);
    case (regSel)
      SEL_STATUS: strobes.rdSrc = RD_STATUS;
      SEL_MASK0:  strobes.rdSrc = RD_MASK0;
      SEL_MASK1:  strobes.rdSrc = RD_MASK1;
      SEL_COUNT:  strobes.rdSrc = RD_COUNT;
      default:    strobes.rdSrc = RD_NONE;
    endcase
  end

  // Hold-off: a FIFO data read blocks refills until the host polls.
  always_ff @(posedge clk) begin
    if (!rstN)         holdQ <= 1'b0;
    else if (fifoRead) holdQ <= 1'b1;
    else if (pollRead) holdQ <= 1'b0;
  end

  assign refillOk = !holdQ;
endmodule

// File: rtl/mmcst_dpath.sv
module mmcst_dpath
  import mmcst_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] evtSet,
  input  logic [CNT_W-1:0]  byteRemain,
  input  logic [REG_W-1:0]  regWdata,
  input  strobes_t          strobes,
  output logic [STAT_W-1:0] statusQ,
  output logic [NUM_IRQ-1:0] irqQ,
  output logic [REG_W-1:0]  regRdata
);
  localparam int CW = CNT_W + 1;
  localparam logic [CLR_W-1:0] STICKY_OK = ~(CLR_W'(1) << RSVD_BIT);

  logic [CLR_W-1:0] clrBits;
  logic [REG_W-1:0] maskQ [NUM_IRQ];
  logic [CW-1:0]    roundSum;
  logic [CW-1:0]    wordCnt;

  assign clrBits = strobes.clrWr ? regWdata[CLR_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ[CLR_W-1:0]      <= ((statusQ[CLR_W-1:0] & ~clrBits)
                                  | evtSet[CLR_W-1:0]) & STICKY_OK;
      statusQ[STAT_W-1:CLR_W] <= evtSet[STAT_W-1:CLR_W];
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gIrq
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[g] <= '0;
        irqQ[g]  <= 1'b0;
      end else begin
        if (strobes.maskWr[g]) maskQ[g] <= regWdata;
        irqQ[g] <= |(statusQ & maskQ[g][STAT_W-1:0]);
      end
    end
  end

  assign roundSum = {1'b0, byteRemain} + CW'(3);
  assign wordCnt  = roundSum >> 2;

  always_comb begin
    case (strobes.rdSrc)
      RD_STATUS: regRdata = REG_W'(statusQ);
      RD_MASK0:  regRdata = maskQ[0];
      RD_MASK1:  regRdata = maskQ[1];
      RD_COUNT:  regRdata = REG_W'(wordCnt);
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/mmc_status_irq.sv
module mmc_status_irq
  import mmcst_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] evtSet,
  input  logic [CNT_W-1:0]  byteRemain,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              refillOk,
  output logic              irq0,
  output logic              irq1
);
  strobes_t           strobes;
  logic [STAT_W-1:0]  statusQ;
  logic [NUM_IRQ-1:0] irqQ;

  mmcst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regRd(regRd), .strobes(strobes), .refillOk(refillOk)
  );

  mmcst_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .byteRemain(byteRemain),
    .regWdata(regWdata), .strobes(strobes), .statusQ(statusQ),
    .irqQ(irqQ), .regRdata(regRdata)
  );

  assign irq0 = irqQ[0];
  assign irq1 = irqQ[1];
endmodule

// File: rtl/mmcst_chk.sv
module mmcst_chk
  import mmcst_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [STAT_W-1:0] evtSet,
  input logic [SEL_W-1:0]  regSel,
  input logic              regWr,
  input logic              regRd,
  input logic [REG_W-1:0]  regWdata,
  input logic [STAT_W-1:0] statusQ,
  input logic              refillOk
);
  logic clrNow;
  assign clrNow = regWr && (regSel == SEL_CLEAR);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clrNow |=> ((statusQ[CLR_W-1:0] & $past(statusQ[CLR_W-1:0])) == $past(statusQ[CLR_W-1:0])));

  assert_rsvd_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[RSVD_BIT] == 1'b0);

  assert_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusQ[STAT_W-1:CLR_W] == $past(evtSet[STAT_W-1:CLR_W]));

  assert_setwins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet[8:0]) |=> ((statusQ[8:0] & $past(evtSet[8:0])) == $past(evtSet[8:0])));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clrNow && evtSet[CLR_W-1:0] == '0) |=> ((statusQ[CLR_W-1:0] & $past(regWdata[CLR_W-1:0])) == '0));

  assert_holdoff_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == SEL_FIFO) |=> !refillOk);

  assert_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && (regSel == SEL_STATUS || regSel == SEL_COUNT)) |=> refillOk);
endmodule

bind mmc_status_irq mmcst_chk u_chk (
  .clk(clk), .rstN(rstN), .evtSet(evtSet), .regSel(regSel), .regWr(regWr),
  .regRd(regRd), .regWdata(regWdata), .statusQ(statusQ), .refillOk(refillOk)
);

// File: tb/sim_mmc_status_irq.sv
module sim_mmc_status_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] evtSet = '0;
  logic [15:0] byteRemain = '0;
  logic [2:0]  regSel = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        refillOk, irq0, irq1;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  logic [21:0] mStat;
  logic [31:0] mMask0, mMask1;
  logic        mIrq0, mIrq1, mHold;

  mmc_status_irq u0 (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .byteRemain(byteRemain),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .refillOk(refillOk), .irq0(irq0), .irq1(irq1)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] sel);
    case (sel)
      3'd0: return {10'b0, mStat};
      3'd2: return mMask0;
      3'd3: return mMask1;
      3'd4: return 32'((17'(byteRemain) + 17'd3) >> 2);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string readReq(input logic [2:0] sel);
    case (sel)
      3'd0: return "R11 status read";
      3'd2, 3'd3: return "R8 mask read";
      3'd4: return "R9 count read";
      default: return "R12 zero read";
    endcase
  endfunction

  // One cycle: inputs driven after a falling edge, results checked before the next.
  task automatic cyc(input logic [21:0] ev, input logic [2:0] sel, input logic wr,
                     input logic rd, input logic [31:0] wd, input logic [15:0] rem);
    logic [10:0] clr;
    evtSet = ev; regSel = sel; regWr = wr; regRd = rd; regWdata = wd; byteRemain = rem;
    #1;
    if (rd) check(readReq(sel), regRdata, expRead(sel));
    @(posedge clk);
    clr = (wr && sel == 3'd1) ? wd[10:0] : 11'h0;
    mIrq0 = |(mStat & mMask0[21:0]);
    mIrq1 = |(mStat & mMask1[21:0]);
    mStat[10:0] = ((mStat[10:0] & ~clr) | ev[10:0]) & 11'h5FF;
    mStat[21:11] = ev[21:11];
    if (wr && sel == 3'd2) mMask0 = wd;
    if (wr && sel == 3'd3) mMask1 = wd;
    if (rd && sel == 3'd5) mHold = 1'b1;
    else if (rd && (sel == 3'd0 || sel == 3'd4)) mHold = 1'b0;
    @(negedge clk);
    check("R7 irq0", 32'(irq0), 32'(mIrq0));
    check("R7 irq1", 32'(irq1), 32'(mIrq1));
    check("R10 refillOk", 32'(refillOk), 32'(!mHold));
  endtask

  initial begin
    #2000000;
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    mStat = '0; mMask0 = '0; mMask1 = '0; mIrq0 = 0; mIrq1 = 0; mHold = 0;
    repeat (3) @(negedge clk);
    check("R1 irq0 in reset", 32'(irq0), 0);
    check("R1 refillOk in reset", 32'(refillOk), 1);
    rstN = 1'b1;
    @(negedge clk);
    // R1: everything reads zero after reset
    cyc('0, 3'd0, 0, 1, 0, 0);
    cyc('0, 3'd2, 0, 1, 0, 0);
    cyc('0, 3'd3, 0, 1, 0, 0);
    // R2/R3: sticky events, reserved bit 9 stays 0
    cyc(22'h0007FF, 3'd0, 0, 0, 0, 0);
    cyc('0, 3'd0, 0, 1, 0, 0);
    // R5: clear with junk high bits; R4 levels unaffected
    cyc(22'h3FF800, 3'd1, 1, 0, 32'hFFFF_F0F0, 0);
    cyc(22'h3FF800, 3'd0, 0, 1, 0, 0);
    // R6: set and clear same bit together
    cyc(22'h000041, 3'd1, 1, 0, 32'h0000_07FF, 0);
    cyc('0, 3'd0, 0, 1, 0, 0);
    // R7/R8: masks and interrupt lines
    cyc('0, 3'd2, 1, 0, 32'hDEAD_0041, 0);
    cyc('0, 3'd3, 1, 0, 32'h0020_0000, 0);
    cyc('0, 3'd2, 0, 1, 0, 0);
    cyc(22'h200000, 3'd3, 0, 1, 0, 0);
    cyc('0, 3'd0, 1, 1, 32'hFFFF_FFFF, 0);  // R8 write to status ignored
    // R9: count boundaries
    cyc('0, 3'd4, 0, 1, 0, 16'd0);
    cyc('0, 3'd4, 0, 1, 0, 16'd1);
    cyc('0, 3'd4, 0, 1, 0, 16'd4);
    cyc('0, 3'd4, 0, 1, 0, 16'd5);
    cyc('0, 3'd4, 0, 1, 0, 16'hFFFF);
    // R10/R11: hold-off sequence
    cyc('0, 3'd5, 0, 1, 0, 0);
    cyc('0, 3'd2, 0, 1, 0, 0);
    cyc('0, 3'd1, 0, 1, 0, 0);
    cyc('0, 3'd4, 0, 1, 0, 16'd9);
    cyc('0, 3'd5, 0, 1, 0, 0);
    cyc('0, 3'd0, 0, 1, 0, 0);
    // R12: unused selects
    cyc('0, 3'd6, 1, 1, 32'hFFFF_FFFF, 0);
    cyc('0, 3'd7, 0, 1, 0, 0);
    // Random traffic mixing events, clears, mask writes and reads
    for (int i = 0; i < 4000; i++) begin
      logic [21:0] ev;
      logic [31:0] wd;
      ev = 22'($urandom) & (($urandom % 3 == 0) ? 22'h3FFFFF : 22'h3FF800 | 22'(1 << ($urandom % 11)));
      wd = $urandom;
      cyc(ev, 3'($urandom % 8), 1'($urandom % 3 == 0), 1'($urandom % 2), wd, 16'($urandom));
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule